// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block watches processor activity on behalf of a debug monitor. It holds a bank of watchpoints. Each one pairs a 32-bit value register with a control register. The control register says which processor quantity to watch: the instruction fetch address, the load/store data or the load/store effective address. It also says how to compare that quantity with the programmed value. When an enabled watchpoint matches, it may ask the pipeline for a breakpoint trap, and a sticky status register records which watchpoints fired.

The timing of the trap depends on the source. A match on the fetch address raises the trap in the same cycle as the fetch, so the pipeline can suppress the instruction before it executes. A match on load/store data or address is held pending and raises the trap only when the instruction-completion strobe arrives. If the access ends in a fault instead, the pending match is discarded. Software programs and inspects the unit through a flat register port.

Top module: `dbg_watch_unit`

## Requirements
- R1: Control bit 0 enables a watchpoint. Control bits 6:5 select its quantity: 0 selects the fetch address, 1 the load/store data, 2 the load/store effective address and 3 nothing. A watchpoint matches only when it is enabled and the valid strobe of its selected source is high.
- R2: Control bits 3:1 hold the compare condition, always evaluated as quantity versus value. The codes are: 0 never, 1 equal, 2 quantity < value, 3 <=, 4 >, 5 >=, 6 not equal, and 7 never.
- R3: Control bit 4 selects a two's-complement compare; when it is clear the compare is unsigned.
- R4: A fetch-address match whose trap-enable bit is set drives trapReq high in the same cycle as fetchValid.
- R5: A data or address match does not raise trapReq in its lsValid cycle. It raises trapReq in the first later cycle in which complete is high and lsFault is low.
- R6: If lsFault is high when the instruction finishes, the pending data matches are dropped: no trap is raised and no status bit is set.
- R7: The trap-enable register holds one bit per watchpoint, and bit i gates the trap of watchpoint i. A match whose bit is clear raises no trap but still sets its status bit.
- R8: Status bit i is set when a match of watchpoint i takes effect (in the fetch cycle, or on completion for data). Bits that take effect together are all set. A bit stays set until software writes a 1 to it.
- R9: Register address bits [ADDR_W-1:IDX_W] select the register kind: 0 value, 1 control, 2 trap enable, 3 status. The low IDX_W bits select the watchpoint. Reads are combinational, and a write takes effect at the next clock edge. Control reads return bits 6:0 and zeros above.
- R10: Synchronous reset clears all control, trap-enable and status bits and all pending data matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchValid | input | 1 | Fetch address valid |
| fetchAddr | input | DATA_W | Instruction fetch address |
| lsValid | input | 1 | Load/store address and data valid |
| lsAddr | input | DATA_W | Load/store effective address |
| lsData | input | DATA_W | Load/store data |
| complete | input | 1 | Load/store instruction completed |
| lsFault | input | 1 | Load/store instruction ended in another exception |
| regAddr | input | ADDR_W | Register address (kind, index) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data |
| trapReq | output | 1 | Breakpoint trap request to the pipeline |

## Verification
trapReq has no register in its path. The bench therefore samples it shortly after the falling edge on which fetchValid or complete is driven, in that same cycle. Status bits and register writes change at the next rising edge. Each read-back of them is therefore issued on the following falling edge, never in the stimulus cycle. The compare conditions are swept for every code, both signedness settings and operand pairs that straddle the sign boundary. Expected results are worked out arithmetically in the bench.

// File: rtl/dbg_watch_pkg.sv
`timescale 1ns/1ps
package dbg_watch_pkg;

  typedef enum logic [2:0] {
    CC_NONE = 3'd0,
    CC_EQ   = 3'd1,
    CC_LT   = 3'd2,
    CC_LE   = 3'd3,
    CC_GT   = 3'd4,
    CC_GE   = 3'd5,
    CC_NE   = 3'd6,
    CC_RSVD = 3'd7
  } wpCond_e;

  typedef enum logic [1:0] {
    SRC_FETCH  = 2'd0,
    SRC_LSDATA = 2'd1,
    SRC_LSADDR = 2'd2,
    SRC_OFF    = 2'd3
  } wpSrc_e;

  // bit 6:5 source, bit 4 signed, bits 3:1 condition, bit 0 enable
  typedef struct packed {
    wpSrc_e  src;
    logic    sgn;
    wpCond_e cond;
    logic    en;
  } wpCtrl_t;

  localparam int CTRL_W = $bits(wpCtrl_t);

  typedef enum logic [1:0] {
    RK_VALUE  = 2'd0,
    RK_CTRL   = 2'd1,
    RK_GEN    = 2'd2,
    RK_STATUS = 2'd3
  } regKind_e;

  typedef struct packed {
    logic wrValue;
    logic wrCtrl;
    logic wrGen;
    logic clrStatus;
  } dpStrobe_t;

endpackage

// File: rtl/dbg_watch_cmp.sv
`timescale 1ns/1ps
module dbg_watch_cmp
  import dbg_watch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] qty,
  input  logic [DATA_W-1:0] value,
  input  wpCond_e           cond,
  input  logic              sgn,
  output logic              hit
);

  logic isLess;
  logic isEqual;

  always_comb begin
    isEqual = (qty == value);
    if (sgn) isLess = ($signed(qty) < $signed(value));
    else     isLess = (qty < value);
  end

  always_comb begin
    unique case (cond)
      CC_EQ:   hit = isEqual;
      CC_LT:   hit = isLess;
      CC_LE:   hit = isLess || isEqual;
      CC_GT:   hit = !isLess && !isEqual;
      CC_GE:   hit = !isLess;
      CC_NE:   hit = !isEqual;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_watch_datapath.sv
`timescale 1ns/1ps
module dbg_watch_datapath
  import dbg_watch_pkg::*;
#(
  parameter int NUM_WP = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          stb,
  input  logic [IDX_W-1:0]   regIdx,
  input  regKind_e           regKind,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_WP-1:0]  setMask,
  input  logic               fetchValid,
  input  logic [DATA_W-1:0]  fetchAddr,
  input  logic               lsValid,
  input  logic [DATA_W-1:0]  lsAddr,
  input  logic [DATA_W-1:0]  lsData,
  output logic [NUM_WP-1:0]  fetchHit,
  output logic [NUM_WP-1:0]  dataHit,
  output logic [NUM_WP-1:0]  genEn,
  output logic [DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] valueArr [NUM_WP];
  wpCtrl_t           ctrlArr  [NUM_WP];
  logic [NUM_WP-1:0] genEnQ;
  logic [NUM_WP-1:0] statusQ;
  logic [NUM_WP-1:0] clrMask;

  for (genvar g = 0; g < NUM_WP; g++) begin : gWp
    logic [DATA_W-1:0] valQ;
    wpCtrl_t           ctlQ;
    logic [DATA_W-1:0] operand;
    logic              cmpHit;
    logic              selHit;

    always_ff @(posedge clk) begin
      if (rst) begin
        valQ <= '0;
        ctlQ <= '0;
      end else begin
        if (stb.wrValue && regIdx == IDX_W'(g)) valQ <= wrData;
        if (stb.wrCtrl && regIdx == IDX_W'(g))  ctlQ <= wpCtrl_t'(wrData[CTRL_W-1:0]);
      end
    end

    always_comb begin
      unique case (ctlQ.src)
        SRC_FETCH:  operand = fetchAddr;
        SRC_LSDATA: operand = lsData;
        SRC_LSADDR: operand = lsAddr;
        default:    operand = '0;
      endcase
    end

    dbg_watch_cmp #(.DATA_W(DATA_W)) cmp_i (
      .qty   (operand),
      .value (valQ),
      .cond  (ctlQ.cond),
      .sgn   (ctlQ.sgn),
      .hit   (cmpHit)
    );

    assign selHit      = ctlQ.en && cmpHit;
    assign fetchHit[g] = selHit && fetchValid && (ctlQ.src == SRC_FETCH);
    assign dataHit[g]  = selHit && lsValid &&
                         ((ctlQ.src == SRC_LSDATA) || (ctlQ.src == SRC_LSADDR));
    assign valueArr[g] = valQ;
    assign ctrlArr[g]  = ctlQ;

    assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (rst)
      !ctlQ.en |-> !(fetchHit[g] || dataHit[g]));
    assert_fetch_gated_R1: assert property (@(posedge clk) disable iff (rst)
      fetchHit[g] |-> fetchValid);
    assert_equal_means_equal_R2: assert property (@(posedge clk) disable iff (rst)
      (fetchHit[g] && ctlQ.cond == CC_EQ) |-> (fetchAddr == valQ));
  end

  assign clrMask = stb.clrStatus ? wrData[NUM_WP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      genEnQ  <= '0;
      statusQ <= '0;
    end else begin
      if (stb.wrGen) genEnQ <= wrData[NUM_WP-1:0];
      statusQ <= (statusQ & ~clrMask) | setMask;
    end
  end

  assign genEn = genEnQ;

  always_comb begin
    unique case (regKind)
      RK_VALUE:  rdData = valueArr[regIdx];
      RK_CTRL:   rdData = DATA_W'(ctrlArr[regIdx]);
      RK_GEN:    rdData = DATA_W'(genEnQ);
      RK_STATUS: rdData = DATA_W'(statusQ);
      default:   rdData = '0;
    endcase
  end

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !stb.clrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
  assert_status_records_R8: assert property (@(posedge clk) disable iff (rst)
    (|setMask) |=> ((statusQ & $past(setMask)) == $past(setMask)));

endmodule

// File: rtl/dbg_watch_ctrl.sv
`timescale 1ns/1ps
module dbg_watch_ctrl
  import dbg_watch_pkg::*;
#(
  parameter int NUM_WP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  regKind_e          regKind,
  input  logic [NUM_WP-1:0] fetchHit,
  input  logic [NUM_WP-1:0] dataHit,
  input  logic [NUM_WP-1:0] genEn,
  input  logic              complete,
  input  logic              lsFault,
  output dpStrobe_t         stb,
  output logic [NUM_WP-1:0] setMask,
  output logic              trapReq
);

  logic [NUM_WP-1:0] pendQ;
  logic              commit;
  logic              drop;

  always_comb begin
    stb.wrValue   = regWrEn && (regKind == RK_VALUE);
    stb.wrCtrl    = regWrEn && (regKind == RK_CTRL);
    stb.wrGen     = regWrEn && (regKind == RK_GEN);
    stb.clrStatus = regWrEn && (regKind == RK_STATUS);
  end

  assign commit = complete && !lsFault;
  assign drop   = complete || lsFault;

  always_ff @(posedge clk) begin
    if (rst) pendQ <= '0;
    else     pendQ <= (drop ? '0 : pendQ) | dataHit;
  end

  assign setMask = fetchHit | (commit ? pendQ : '0);
  assign trapReq = (|(fetchHit & genEn)) || (commit && (|(pendQ & genEn)));

  assert_data_waits_R5: assert property (@(posedge clk) disable iff (rst)
    (pendQ == '0 && fetchHit == '0) |-> !trapReq);
  assert_fault_no_trap_R6: assert property (@(posedge clk) disable iff (rst)
    (lsFault && fetchHit == '0) |-> !trapReq);
  assert_pending_drained_R6: assert property (@(posedge clk) disable iff (rst)
    (drop && dataHit == '0) |=> (pendQ == '0));
  assert_gen_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (genEn == '0) |-> !trapReq);

endmodule

// File: rtl/dbg_watch_unit.sv
`timescale 1ns/1ps
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int NUM_WP = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              lsValid,
  input  logic [DATA_W-1:0] lsAddr,
  input  logic [DATA_W-1:0] lsData,
  input  logic              complete,
  input  logic              lsFault,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              trapReq
);

  regKind_e          kindSel;
  logic [IDX_W-1:0]  idxSel;
  dpStrobe_t         stb;
  logic [NUM_WP-1:0] setMask;
  logic [NUM_WP-1:0] fetchHit;
  logic [NUM_WP-1:0] dataHit;
  logic [NUM_WP-1:0] genEn;

  assign kindSel = regKind_e'(regAddr[ADDR_W-1:IDX_W]);
  assign idxSel  = regAddr[IDX_W-1:0];

  dbg_watch_ctrl #(.NUM_WP(NUM_WP)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .regWrEn  (regWrEn),
    .regKind  (kindSel),
    .fetchHit (fetchHit),
    .dataHit  (dataHit),
    .genEn    (genEn),
    .complete (complete),
    .lsFault  (lsFault),
    .stb      (stb),
    .setMask  (setMask),
    .trapReq  (trapReq)
  );

  dbg_watch_datapath #(.NUM_WP(NUM_WP), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .regIdx     (idxSel),
    .regKind    (kindSel),
    .wrData     (regWrData),
    .setMask    (setMask),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr),
    .lsValid    (lsValid),
    .lsAddr     (lsAddr),
    .lsData     (lsData),
    .fetchHit   (fetchHit),
    .dataHit    (dataHit),
    .genEn      (genEn),
    .rdData     (regRdData)
  );

endmodule

// File: tb/dbg_watch_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_watch_unit_tb_top;

  localparam int NUM_WP = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetchValid = 1'b0;
  logic [DATA_W-1:0] fetchAddr = '0;
  logic              lsValid = 1'b0;
  logic [DATA_W-1:0] lsAddr = '0;
  logic [DATA_W-1:0] lsData = '0;
  logic              complete = 1'b0;
  logic              lsFault = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              trapReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_watch_unit #(.NUM_WP(NUM_WP), .DATA_W(DATA_W)) dut_i (
    .clk, .rst, .fetchValid, .fetchAddr, .lsValid, .lsAddr, .lsData,
    .complete, .lsFault, .regAddr, .regWrEn, .regWrData, .regRdData, .trapReq
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int kind, int idx, logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'((kind << 3) | idx);
    regWrData = data;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int kind, int idx, output logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'((kind << 3) | idx);
    #1 data = regRdData;
  endtask

  function automatic bit expHit(int cc, bit s, logic [31:0] q, logic [31:0] v);
    bit lt = s ? ($signed(q) < $signed(v)) : (q < v);
    bit eq = (q == v);
    case (cc)
      1: return eq;
      2: return lt;
      3: return lt || eq;
      4: return !lt && !eq;
      5: return !lt;
      6: return !eq;
      default: return 1'b0;
    endcase
  endfunction

  // one fetch cycle; returns trapReq sampled inside it
  task automatic fetchOnce(logic [31:0] a, output logic t);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a;
    #1 t = trapReq;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  // load/store cycle, one idle cycle, then finish; returns trap in ls and finish cycles
  task automatic lsOp(logic [31:0] a, logic [31:0] d, bit fault,
                      output logic tLs, output logic tEnd);
    @(negedge clk);
    lsValid = 1'b1; lsAddr = a; lsData = d;
    #1 tLs = trapReq;
    @(negedge clk);
    lsValid = 1'b0;
    @(negedge clk);
    complete = 1'b1; lsFault = fault;
    #1 tEnd = trapReq;
    @(negedge clk);
    complete = 1'b0; lsFault = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic t, t2;
    logic [31:0] qs [6];
    logic [31:0] vs [6];
    qs[0] = 32'd5;        vs[0] = 32'd5;
    qs[1] = 32'd5;        vs[1] = 32'd6;
    qs[2] = 32'd6;        vs[2] = 32'd5;
    qs[3] = 32'hFFFFFFFF; vs[3] = 32'd1;
    qs[4] = 32'd1;        vs[4] = 32'hFFFFFFFF;
    qs[5] = 32'h80000000; vs[5] = 32'h7FFFFFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(3, 0, r); chk("R10 status after reset", r, 32'h0);
    rd(2, 0, r); chk("R10 trap enable after reset", r, 32'h0);
    rd(1, 0, r); chk("R10 control after reset", r, 32'h0);
    fetchOnce(32'h0, t); chk("R10 no trap after reset", {31'd0, t}, 32'd0);

    // R2 R3 condition sweep on watchpoint 0, fetch source
    wr(2, 0, 32'h1);
    for (int cc = 0; cc < 8; cc++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 6; p++) begin
          wr(0, 0, vs[p]);
          wr(1, 0, 32'((s << 4) | (cc << 1) | 1));
          fetchOnce(qs[p], t);
          chk($sformatf("R2 R3 R4 cc=%0d sgn=%0d pair=%0d", cc, s, p),
              {31'd0, t}, {31'd0, expHit(cc, s[0], qs[p], vs[p])});
        end
      end
    end
    rd(3, 0, r); chk("R8 status after sweep", r, 32'h1);
    wr(3, 0, 32'h1);
    rd(3, 0, r); chk("R8 write one clears", r, 32'h0);

    // R1 source selection on watchpoint 3
    wr(1, 0, 32'h0);
    wr(2, 0, 32'h09);
    wr(0, 3, 32'h1000);
    wr(1, 3, 32'h43);                      // effective address, equal, enabled
    fetchOnce(32'h1000, t); chk("R1 address watch ignores fetch", {31'd0, t}, 32'd0);
    lsOp(32'h1000, 32'h0, 1'b0, t, t2);
    chk("R5 no trap in access cycle", {31'd0, t}, 32'd0);
    chk("R5 trap on completion", {31'd0, t2}, 32'd1);
    @(negedge clk); #1 chk("R5 trap lasts one cycle", {31'd0, trapReq}, 32'd0);
    rd(3, 0, r); chk("R8 status for data match", r, 32'h08);
    wr(3, 0, 32'hFF);
    wr(1, 3, 32'h23);                      // load/store data, equal
    lsOp(32'h0, 32'h1000, 1'b0, t, t2); chk("R1 data source match", {31'd0, t2}, 32'd1);
    lsOp(32'h1000, 32'h0, 1'b0, t, t2); chk("R1 data source ignores address", {31'd0, t2}, 32'd0);
    wr(1, 3, 32'h22);                      // disabled
    lsOp(32'h0, 32'h1000, 1'b0, t, t2); chk("R1 disabled watchpoint", {31'd0, t2}, 32'd0);
    wr(1, 3, 32'h63);                      // source none
    lsOp(32'h1000, 32'h1000, 1'b0, t, t2); chk("R1 source none", {31'd0, t2}, 32'd0);
    fetchOnce(32'h1000, t); chk("R1 source none fetch", {31'd0, t}, 32'd0);
    wr(3, 0, 32'hFF);

    // R6 fault discards pending match
    wr(1, 3, 32'h23);
    lsOp(32'h0, 32'h1000, 1'b1, t, t2); chk("R6 no trap with fault", {31'd0, t2}, 32'd0);
    @(negedge clk); complete = 1'b1;
    #1 chk("R6 pending dropped", {31'd0, trapReq}, 32'd0);
    @(negedge clk); complete = 1'b0;
    rd(3, 0, r); chk("R6 no status after fault", r, 32'h0);

    // R7 trap enable per watchpoint
    wr(0, 5, 32'h2000);
    wr(1, 5, 32'h03);                      // fetch, equal
    fetchOnce(32'h2000, t); chk("R7 no trap with enable clear", {31'd0, t}, 32'd0);
    rd(3, 0, r); chk("R7 status still set", r, 32'h20);

    // R8 simultaneous set and selective clear
    wr(0, 6, 32'h0);
    wr(1, 6, 32'h0B);                      // fetch, >=, unsigned
    fetchOnce(32'h2000, t);
    rd(3, 0, r); chk("R8 two bits set together", r, 32'h60);
    wr(3, 0, 32'h20);
    rd(3, 0, r); chk("R8 selective clear", r, 32'h40);
    wr(3, 0, 32'h0);
    rd(3, 0, r); chk("R8 writing zero keeps bits", r, 32'h40);

    // R4 fetch trap same cycle
    wr(2, 0, 32'h29);
    wr(1, 6, 32'h0);
    fetchOnce(32'h2000, t); chk("R4 fetch trap same cycle", {31'd0, t}, 32'd1);

    // R9 register map
    rd(0, 3, r); chk("R9 value readback", r, 32'h1000);
    rd(2, 0, r); chk("R9 trap enable readback", r, 32'h29);
    wr(1, 6, 32'hFFFFFF8B);
    rd(1, 6, r); chk("R9 control readback width", r, 32'h0B);

    // R10 reset drops pending match
    wr(1, 3, 32'h23);
    wr(2, 0, 32'h08);
    @(negedge clk); lsValid = 1'b1; lsData = 32'h1000;
    @(negedge clk); lsValid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(2, 0, 32'h08);
    wr(1, 3, 32'h23);
    @(negedge clk); complete = 1'b1;
    #1 chk("R10 pending cleared by reset", {31'd0, trapReq}, 32'd0);
    @(negedge clk); complete = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule